// File: doc/BRIEF.md
# Block Address Translation Unit

This unit translates a 32-bit effective address through a small set of programmable address windows. It keeps two banks of window descriptors, one for instruction fetches and one for data accesses. Each descriptor is a pair of 32-bit words: a match word and a translation word. A lookup compares the address against every descriptor of the selected bank in parallel. The lowest-numbered descriptor that qualifies wins and supplies the physical page number and the access rights. The result is registered and appears one clock after the request.

Each window has its own size. A length mask in the match word marks which of address bits [27:17] are free: those bits skip the comparison and are carried into the physical page. The other bits in that range must match the stored value. Supervisor and user accesses each have their own enable bit in every descriptor. When no descriptor qualifies, the unit flags a miss and records the faulting address. The surrounding memory-management logic uses this flag to fall back to page-table translation or to raise a fault.

Descriptors are written through a simple write port. The select code of the port picks the bank, the word of the pair and the descriptor index. A write is visible to the first lookup issued in the cycle after the write.

Top module: `bat_xlate`

## Requirements
- R1: After a synchronous reset every descriptor word is zero, so every lookup misses. All response outputs and the fault-address register are zero.
- R2: A lookup with `req_code`=1 searches only the instruction bank. A lookup with `req_code`=0 searches only the data bank.
- R3: A descriptor qualifies only if address bits [31:28] equal match-word bits [31:28].
- R4: The length mask is match-word bits [12:2], laid over address bits [27:17]. Each address bit in [27:17] whose mask bit is 0 must equal the same bit of the match word. Address bits whose mask bit is 1 are not compared. Match-word bits [16:13] are ignored.
- R5: Match-word bit 1 enables the descriptor for supervisor accesses (`req_user`=0). Match-word bit 0 enables it for user accesses (`req_user`=1). A descriptor whose bit for the current mode is clear never qualifies.
- R6: On a hit, `rsp_page` (physical address bits [31:12]) is formed from three parts, high to low. Bits [31:28] are translation-word bits [31:28]. Bits [27:17] are the OR of the mask-selected address bits [27:17] with translation-word bits [27:17]. Bits [16:12] are address bits [16:12].
- R7: On a hit, translation-word bit 1 gives read and write rights (`rsp_rd`=1, `rsp_wr`=1) whatever bit 0 holds. Bit 0 alone gives read-only rights. If both bits are 0, the unit still reports a hit, with `rsp_rd`=`rsp_wr`=0.
- R8: When several descriptors qualify, the one with the lowest index supplies the result.
- R9: When no descriptor qualifies, `rsp_miss`=1, `rsp_page`, `rsp_rd` and `rsp_wr` are 0, and `fault_ea` takes the request address. `fault_ea` changes only on a miss.
- R10: `cfg_sel` is decoded as follows. Bit 3 picks the bank (1 = instruction, 0 = data). Bit 2 picks the word (1 = translation, 0 = match). Bits [1:0] give the descriptor index. A lookup issued in the same cycle as a write uses the old contents. A lookup in any later cycle uses the new contents.
- R11: `rsp_valid`, `rsp_hit` and `rsp_miss` follow `req_valid` by exactly one clock. Exactly one of `rsp_hit` and `rsp_miss` is set when `rsp_valid` is 1, and neither is set otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_ea | input | 32 | Effective address to translate |
| req_code | input | 1 | 1 = instruction fetch, 0 = data access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| cfg_we | input | 1 | Descriptor write enable |
| cfg_sel | input | 4 | Bank / word / index select for the write |
| cfg_wdata | input | 32 | Descriptor write data |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A descriptor translated the address |
| rsp_miss | output | 1 | No descriptor qualified |
| rsp_page | output | 20 | Physical address bits [31:12] |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| fault_ea | output | 32 | Address of the most recent miss |

## Verification
A corrupted descriptor word or a wrong bank-select path shows up on the response of the very next lookup that lands in the affected window. It appears as a wrong page, wrong rights, or a hit and a miss swapped. A wrong priority order appears only when windows overlap, so the directed checks and the random configurations both program overlapping windows on purpose. A fault-address register that updates when it should not shows up at the following response, because `fault_ea` is compared after every lookup and after idle cycles.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int WORD_W = 32;
  localparam int PAGE_W = 20;
  localparam int LEN_W  = 11;

  typedef logic [WORD_W-1:0] bat_word_t;
  typedef logic [PAGE_W-1:0] bat_page_t;
endpackage

// File: rtl/bat_regs.sv
module bat_regs
  import bat_pkg::*;
#(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N),
  localparam int SEL_W = IDX_W + 2,
  localparam int DEPTH = 4 * N
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [SEL_W-1:0]     sel,
  input  bat_word_t            wdata,
  input  logic                 rd_code,
  output bat_word_t [N-1:0]    up_q,
  output bat_word_t [N-1:0]    lo_q
);
  bat_word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[sel] <= wdata;
    end
  end

  // Parallel read of the whole bank: each descriptor feeds its own comparator.
  for (genvar e = 0; e < N; e++) begin : g_rd
    localparam logic [IDX_W-1:0] EI = IDX_W'(e);
    assign up_q[e] = mem[{rd_code, 1'b0, EI}];
    assign lo_q[e] = mem[{rd_code, 1'b1, EI}];
  end

  // R10
  cfg_store_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(sel)] == $past(wdata)));
endmodule

// File: rtl/bat_entry_cmp.sv
module bat_entry_cmp
  import bat_pkg::*;
(
  input  bat_word_t ea,
  input  bat_word_t up,
  input  bat_word_t lo,
  input  logic      user,
  output logic      qual,
  output bat_page_t page,
  output logic      rd,
  output logic      wr
);
  logic [LEN_W-1:0] len_mask;
  logic             tag_ok;
  logic             mid_ok;
  logic             mode_ok;

  always_comb begin
    len_mask = up[12:2];
    tag_ok   = (ea[31:28] == up[31:28]);
    mid_ok   = ((ea[27:17] & ~len_mask) == up[27:17]);
    mode_ok  = user ? up[0] : up[1];
    qual     = tag_ok && mid_ok && mode_ok;
    page     = {lo[31:28], (ea[27:17] & len_mask) | lo[27:17], ea[16:12]};
    wr       = lo[1];
    rd       = lo[1] | lo[0];
  end
endmodule

// File: rtl/bat_first_hit.sv
module bat_first_hit
  import bat_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         qual,
  input  bat_page_t [N-1:0]    page_in,
  input  logic [N-1:0]         rd_in,
  input  logic [N-1:0]         wr_in,
  output logic                 any,
  output bat_page_t            page,
  output logic                 rd,
  output logic                 wr
);
  logic [N-1:0] grant;
  logic         found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (qual[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    page = '0;
    rd   = 1'b0;
    wr   = 1'b0;
    for (int i = 0; i < N; i++) begin
      page = page | (page_in[i] & {PAGE_W{grant[i]}});
      rd   = rd | (rd_in[i] & grant[i]);
      wr   = wr | (wr_in[i] & grant[i]);
    end
    any = |grant;
  end

  // R8
  lowest_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (qual != '0) |-> ($onehot(grant) && ((grant & qual) == grant) &&
                      ((qual & (grant - 1'b1)) == '0)));
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  localparam int SEL_W = $clog2(N_ENTRIES) + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [31:0]      req_ea,
  input  logic             req_code,
  input  logic             req_user,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic [19:0]      rsp_page,
  output logic             rsp_rd,
  output logic             rsp_wr,
  output logic [31:0]      fault_ea
);
  bat_word_t [N_ENTRIES-1:0] up_w;
  bat_word_t [N_ENTRIES-1:0] lo_w;
  logic      [N_ENTRIES-1:0] e_qual;
  bat_page_t [N_ENTRIES-1:0] e_page;
  logic      [N_ENTRIES-1:0] e_rd;
  logic      [N_ENTRIES-1:0] e_wr;
  logic                      sel_any;
  bat_page_t                 sel_page;
  logic                      sel_rd;
  logic                      sel_wr;

  bat_regs #(.N(N_ENTRIES)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .sel     (cfg_sel),
    .wdata   (cfg_wdata),
    .rd_code (req_code),
    .up_q    (up_w),
    .lo_q    (lo_w)
  );

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
    bat_entry_cmp u_cmp (
      .ea   (req_ea),
      .up   (up_w[e]),
      .lo   (lo_w[e]),
      .user (req_user),
      .qual (e_qual[e]),
      .page (e_page[e]),
      .rd   (e_rd[e]),
      .wr   (e_wr[e])
    );
  end

  bat_first_hit #(.N(N_ENTRIES)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .qual    (e_qual),
    .page_in (e_page),
    .rd_in   (e_rd),
    .wr_in   (e_wr),
    .any     (sel_any),
    .page    (sel_page),
    .rd      (sel_rd),
    .wr      (sel_wr)
  );

  logic take_hit;
  logic take_miss;
  assign take_hit  = req_valid && sel_any;
  assign take_miss = req_valid && !sel_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_page  <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      fault_ea  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= take_hit;
      rsp_miss  <= take_miss;
      rsp_page  <= take_hit ? sel_page : '0;
      rsp_rd    <= take_hit && sel_rd;
      rsp_wr    <= take_hit && sel_wr;
      if (take_miss) fault_ea <= req_ea;
    end
  end

  // R11
  rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(req_valid));

  // R11
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (!(rsp_hit && rsp_miss)) && ((rsp_hit || rsp_miss) == rsp_valid));

  // R9
  fault_capture_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (fault_ea == $past(req_ea)));

  // R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_miss |-> $stable(fault_ea));

  // R7
  wr_has_rd_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_wr |-> rsp_rd);

  // R9
  miss_clean_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (!rsp_rd && !rsp_wr && rsp_page == '0));
endmodule

// File: tb/bat_xlate_bench.sv
`timescale 1ns/1ps
module bat_xlate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic        req_code = 1'b0;
  logic        req_user = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_rd, rsp_wr;
  logic [19:0] rsp_page;
  logic [31:0] fault_ea;

  always #2.5 clk = ~clk;

  bat_xlate u_bat_xlate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ea(req_ea),
    .req_code(req_code), .req_user(req_user), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_page(rsp_page),
    .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .fault_ea(fault_ea)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] su [2][4];
  logic [31:0] sl [2][4];
  logic [31:0] exp_fault = '0;
  logic [31:0] rng = 32'h1BAD_5EED;

  function automatic logic [31:0] rnd_step(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic rnd(output logic [31:0] v);
    rng = rnd_step(rng);
    v = rng;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] ea, input logic code, input logic user,
                       output logic hit, output logic [19:0] pg,
                       output logic rd, output logic wr);
    int b = code ? 1 : 0;
    hit = 0; pg = '0; rd = 0; wr = 0;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] u = su[b][k];
      logic [31:0] l = sl[b][k];
      logic [10:0] m = u[12:2];
      if (!hit && ea[31:28] == u[31:28] && ((ea[27:17] & ~m) == u[27:17]) &&
          (user ? u[0] : u[1])) begin
        hit = 1;
        pg  = {l[31:28], (ea[27:17] & m) | l[27:17], ea[16:12]};
        wr  = l[1];
        rd  = l[1] | l[0];
      end
    end
  endtask

  task automatic shadow(input logic [3:0] sel, input logic [31:0] d);
    if (sel[2]) sl[sel[3]][sel[1:0]] = d;
    else        su[sel[3]][sel[1:0]] = d;
  endtask

  task automatic cfg_write(input logic [3:0] sel, input logic [31:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    shadow(sel, d);
  endtask

  task automatic do_lookup(input logic [31:0] ea, input logic code, input logic user,
                           input string tag);
    logic h, r, w;
    logic [19:0] p;
    model(ea, code, user, h, p, r, w);
    req_valid = 1; req_ea = ea; req_code = code; req_user = user;
    @(negedge clk);
    req_valid = 0;
    if (!h) exp_fault = ea;
    chk({tag, " hit"},   {31'b0, rsp_hit},  {31'b0, h});
    chk({tag, " miss"},  {31'b0, rsp_miss}, {31'b0, !h});
    chk({tag, " page"},  {12'b0, rsp_page}, {12'b0, p});
    chk({tag, " rd"},    {31'b0, rsp_rd},   {31'b0, r});
    chk({tag, " wr"},    {31'b0, rsp_wr},   {31'b0, w});
    chk({tag, " fault"}, fault_ea, exp_fault);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 4; k++) begin su[b][k] = '0; sl[b][k] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 valid", {31'b0, rsp_valid}, 0);
    chk("R1 hit",   {31'b0, rsp_hit}, 0);
    chk("R1 miss",  {31'b0, rsp_miss}, 0);
    chk("R1 fault", fault_ea, 0);
    do_lookup(32'h1234_5000, 0, 0, "R1 empty");
    do_lookup(32'h0000_0000, 1, 1, "R1 empty");

    // R10: write and lookup in the same cycle use old contents
    cfg_we = 1; cfg_sel = 4'b0000; cfg_wdata = 32'h1000_0002;
    req_valid = 1; req_ea = 32'h1000_3000; req_code = 0; req_user = 0;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    exp_fault = 32'h1000_3000;
    chk("R10 same-cycle miss", {31'b0, rsp_miss}, 1);
    chk("R10 same-cycle fault", fault_ea, exp_fault);
    shadow(4'b0000, 32'h1000_0002);
    do_lookup(32'h1000_3000, 0, 0, "R10 next-cycle");
    // R7: hit with no rights (translation word still zero)
    chk("R7 norights hit", {31'b0, rsp_hit}, 1);
    chk("R7 norights rd", {31'b0, rsp_rd}, 0);

    // R11: idle cycle leaves response low and fault held
    @(negedge clk);
    chk("R11 idle valid", {31'b0, rsp_valid}, 0);
    chk("R11 idle hit", {31'b0, rsp_hit | rsp_miss}, 0);
    chk("R9 fault held", fault_ea, exp_fault);

    // R8: overlapping windows, lowest index wins
    cfg_write(4'b0001, 32'h1000_0002);
    cfg_write(4'b0101, 32'h8000_0002);
    cfg_write(4'b0100, 32'h4000_0001);
    do_lookup(32'h1000_3000, 0, 0, "R8 entry0");
    chk("R8 page0", {12'b0, rsp_page}, 32'h0004_0003);
    cfg_write(4'b0000, 32'h1000_0001);
    do_lookup(32'h1000_3000, 0, 0, "R8 entry1");
    chk("R8 page1", {12'b0, rsp_page}, 32'h0008_0003);
    // R5: user mode picks entry0 now
    do_lookup(32'h1000_3000, 0, 1, "R5 user");
    chk("R5 user page", {12'b0, rsp_page}, 32'h0004_0003);
    // R2: instruction bank is empty
    do_lookup(32'h1000_3000, 1, 0, "R2 code bank");
    chk("R2 code miss", {31'b0, rsp_miss}, 1);
    // R4: mask over bits [18:17], page carries masked bits
    cfg_write(4'b1000, 32'h2000_000E);
    cfg_write(4'b1100, 32'h3000_0002);
    do_lookup(32'h2006_5000, 1, 0, "R4 masked");
    chk("R4 page", {12'b0, rsp_page}, 32'h0003_0065);
    do_lookup(32'h2008_5000, 1, 0, "R3 R4 unmasked bit");
    chk("R4 miss", {31'b0, rsp_miss}, 1);
    do_lookup(32'h3006_5000, 1, 0, "R3 top nibble");
    chk("R3 miss", {31'b0, rsp_miss}, 1);

    // Random configurations with address sweep
    for (int ph = 0; ph < 4; ph++) begin
      for (int s = 0; s < 16; s++) begin
        logic [31:0] r1, r2, r3, u;
        logic [10:0] bl;
        rnd(r1); rnd(r2); rnd(r3);
        case (ph)
          0: bl = 11'h000;
          1: bl = 11'h7FF;
          2: bl = r1[20:10] & 11'h00F;
          default: bl = r1[20:10];
        endcase
        u = {2'b00, r1[1:0], (r2[27:17] & ((r3[2:0] == 0) ? 11'h7FF : ~bl)),
             r3[16:13], bl, r3[9:8]};
        cfg_write(4'(s), s[2] ? r2 ^ r3 : u);
      end
      for (int n = 0; n < 600; n++) begin
        logic [31:0] r, a, b1, b2, m32;
        int bk, ek, sh;
        rnd(r); rnd(b1); rnd(b2);
        bk = r[2] ? 1 : 0;
        ek = int'(r[1:0]);
        m32 = {4'b0, su[bk][ek][12:2], 17'b0};
        a = (su[bk][ek] & 32'hFFFE_0000 & ~m32) | (b1 & m32) | (b2 & 32'h0001_FFFF);
        if (r[4:3] == 2'b00) begin
          sh = 17 + (int'(r[9:5]) % 15);
          a = a ^ (32'h1 << sh);
        end
        do_lookup(a, r[2], r[10], "R2 R3 R4 R5 R6 R7 R8 R9 sweep");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule